// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the four threshold offsets that a pair of FIFOs uses for their almost-full and almost-empty flags. The offsets are X1 and Y1 for the first FIFO and X2 and Y2 for the second. The block fills them by one of three methods. The method is fixed when the master reset input is released.

In preset mode, all four offsets take the same constant: 8, 16 or 64. In parallel mode, four consecutive write strobes on the data port fill the registers one at a time. In serial mode, one bit is shifted in on every clock edge on which the serial enable is low. Once the offsets are complete, a done flag rises. The flag comparison logic and the FIFO storage that use these offsets are outside this block.

Top module: `flag_offset_loader`

## Requirements
- R1: While `mst_rst_n` is low, `done` is 0. Once the reset is released in serial or parallel mode, all four offsets read 0 until the first accepted load.
- R2: The method is set by the pin levels on the last clock edge with `mst_rst_n` low. Later changes on `ser_mode_n` or `fsel` have no effect until the next master reset.
- R3: Preset mode is selected by `ser_mode_n`=1 with `fsel` equal to 01, 10 or 11, giving 8, 16 or 64 respectively. All four offsets hold that value, and `done` is 1 from the first clock edge after release.
- R4: Serial mode is selected by `ser_mode_n`=0, and `fsel` is then ignored. Each clock edge with `ser_en_n`=0 shifts in `ser_din`. The bit stream fills Y1, X1, Y2 and X2 in that order, each most significant bit first. The first bit is therefore the MSB of Y1 and the last bit is the LSB of X2.
- R5: In serial mode, `done` stays 0 after 4*OFS_W-1 accepted bits. It is 1 right after the clock edge that accepts bit 4*OFS_W.
- R6: In serial mode, bits presented after `done` has risen leave the offsets unchanged.
- R7: Parallel mode is selected by `ser_mode_n`=1 with `fsel`=00. The first four clock edges with `par_wr`=1 load `par_data` into X1, Y1, X2 and Y2 in that order. `done` rises after the fourth write.
- R8: In parallel mode, write strobes after the fourth leave the offsets unchanged.
- R9: Each method ignores the inputs of the other methods. `par_wr` has no effect in serial or preset mode, and `ser_en_n` has no effect in parallel or preset mode.
- R10: Asserting `mst_rst_n` again clears a load in progress or a finished load, and captures a new method.
- R11: Once `done` is 1, the offsets and `done` hold their values until the next master reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state, released synchronously |
| mst_rst_n | input | 1 | Master reset, active low; releasing it fixes the method |
| ser_mode_n | input | 1 | 0 selects serial loading, 1 selects parallel or preset |
| fsel | input | 2 | 00 selects parallel; 01, 10 and 11 select presets 8, 16 and 64 |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_din | input | 1 | Serial data bit |
| par_data | input | OFS_W | Parallel offset value |
| par_wr | input | 1 | Parallel write strobe |
| x1_ofs | output | OFS_W | Offset X1 |
| y1_ofs | output | OFS_W | Offset Y1 |
| x2_ofs | output | OFS_W | Offset X2 |
| y2_ofs | output | OFS_W | Offset Y2 |
| done | output | 1 | Offsets complete |

## Verification
A parallel write strobe and a serial shift enable can arrive in the same cycle, and only the one that matches the captured method may act. The bench drives random `par_wr` and `par_data` during every serial load, and random `ser_en_n` and `ser_din` during every parallel load, including in the cycles of accepted transfers. It then compares all four offsets with the values expected from the active method's stream alone. A second collision is a master reset that arrives part-way through a serial load. The bench judges it by the offsets reading zero and by the next method loading cleanly.

// File: rtl/ofl_pkg.sv
package ofl_pkg;
  typedef enum logic [1:0] {
    LD_PAR = 2'd0,
    LD_DEF = 2'd1,
    LD_SER = 2'd2
  } ld_mode_e;

  function automatic ld_mode_e pick_mode(input logic ser_n, input logic [1:0] sel);
    if (!ser_n)          return LD_SER;
    else if (sel == 2'd0) return LD_PAR;
    else                  return LD_DEF;
  endfunction

  function automatic logic [9:0] preset_val(input logic [1:0] sel);
    case (sel)
      2'd1:    return 10'd8;
      2'd2:    return 10'd16;
      2'd3:    return 10'd64;
      default: return 10'd0;
    endcase
  endfunction
endpackage

// File: rtl/ofl_mode_cap.sv
module ofl_mode_cap
  import ofl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mst_rst_n,
  input  logic           ser_mode_n,
  input  logic [1:0]     fsel,
  output ld_mode_e       mode_q,
  output logic [W-1:0]   dflt_q,
  output logic           armed_q
);
  ld_mode_e     mode_d;
  logic [W-1:0] dflt_d;
  logic         armed_d;

  always_comb begin
    mode_d  = mode_q;
    dflt_d  = dflt_q;
    armed_d = mst_rst_n;
    if (!mst_rst_n) begin
      mode_d = pick_mode(ser_mode_n, fsel);
      dflt_d = W'(preset_val(fsel));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LD_PAR;
      dflt_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      dflt_q  <= dflt_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/ofl_ser_shift.sv
module ofl_ser_shift #(
  parameter int W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             sdi,
  output logic [4*W-1:0]   vec_q,
  output logic             done
);
  localparam int NB = 4 * W;
  localparam int CW = $clog2(NB + 1);

  logic [NB-1:0] vec_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign done = (cnt_q == CW'(NB));

  always_comb begin
    vec_d = vec_q;
    cnt_d = cnt_q;
    if (clr) begin
      vec_d = '0;
      cnt_d = '0;
    end else if (en && !done) begin
      vec_d = {vec_q[NB-2:0], sdi};
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      cnt_q <= '0;
    end else begin
      vec_q <= vec_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/ofl_par_load.sv
module ofl_par_load #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic [W-1:0]         din,
  output logic [3:0][W-1:0]    ofs_q,
  output logic                 done
);
  localparam int NREG = 4;

  logic [2:0] idx_q, idx_d;

  assign done = idx_q[2];

  always_comb begin
    idx_d = idx_q;
    if (clr)              idx_d = '0;
    else if (en && !done) idx_d = idx_q + 3'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic          hit;
    logic [W-1:0]  slot_d;
    assign hit = en && !done && (idx_q[1:0] == 2'(g));
    always_comb begin
      slot_d = ofs_q[g];
      if (clr)      slot_d = '0;
      else if (hit) slot_d = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_q[g] <= '0;
      else        ofs_q[g] <= slot_d;
    end
  end
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
  import ofl_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mst_rst_n,
  input  logic             ser_mode_n,
  input  logic [1:0]       fsel,
  input  logic             ser_en_n,
  input  logic             ser_din,
  input  logic [OFS_W-1:0] par_data,
  input  logic             par_wr,
  output logic [OFS_W-1:0] x1_ofs,
  output logic [OFS_W-1:0] y1_ofs,
  output logic [OFS_W-1:0] x2_ofs,
  output logic [OFS_W-1:0] y2_ofs,
  output logic             done
);
  localparam int W = OFS_W;

  ld_mode_e               mode_q;
  logic [W-1:0]           dflt_q;
  logic                   armed_q;
  logic                   clr, ser_en, par_en;
  logic [4*W-1:0]         ser_vec;
  logic                   ser_done;
  logic [3:0][W-1:0]      par_ofs;
  logic                   par_done;

  assign clr    = !mst_rst_n;
  assign ser_en = (mode_q == LD_SER) && !ser_en_n;
  assign par_en = (mode_q == LD_PAR) && par_wr;

  ofl_mode_cap #(.W(W)) u_mode (
    .clk(clk), .rst_n(rst_n), .mst_rst_n(mst_rst_n),
    .ser_mode_n(ser_mode_n), .fsel(fsel),
    .mode_q(mode_q), .dflt_q(dflt_q), .armed_q(armed_q)
  );

  ofl_ser_shift #(.W(W)) u_ser (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(ser_en), .sdi(ser_din),
    .vec_q(ser_vec), .done(ser_done)
  );

  ofl_par_load #(.W(W)) u_par (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(par_en), .din(par_data),
    .ofs_q(par_ofs), .done(par_done)
  );

  always_comb begin
    case (mode_q)
      LD_SER: begin
        y1_ofs = ser_vec[4*W-1:3*W];
        x1_ofs = ser_vec[3*W-1:2*W];
        y2_ofs = ser_vec[2*W-1:W];
        x2_ofs = ser_vec[W-1:0];
        done   = ser_done;
      end
      LD_DEF: begin
        x1_ofs = dflt_q;
        y1_ofs = dflt_q;
        x2_ofs = dflt_q;
        y2_ofs = dflt_q;
        done   = armed_q;
      end
      default: begin
        x1_ofs = par_ofs[0];
        y1_ofs = par_ofs[1];
        x2_ofs = par_ofs[2];
        y2_ofs = par_ofs[3];
        done   = par_done;
      end
    endcase
  end
endmodule

// File: rtl/ofl_chk.sv
module ofl_chk
  import ofl_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mst_rst_n,
  input logic         ser_en_n,
  input logic         par_wr,
  input ld_mode_e     mode,
  input logic [W-1:0] x1,
  input logic [W-1:0] y1,
  input logic [W-1:0] x2,
  input logic [W-1:0] y2,
  input logic         done
);
  // R1
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mst_rst_n |=> !done);

  // R11
  hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mst_rst_n) |=> (done && $stable({x1, y1, x2, y2})));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mst_rst_n |=> $stable(mode));

  // R9
  foreign_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_rst_n && !(mode == LD_SER && !ser_en_n) && !(mode == LD_PAR && par_wr))
      |=> $stable({x1, y1, x2, y2}));

  // R3
  preset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == LD_DEF) |->
      (x1 == y1 && x1 == x2 && x1 == y2 &&
       (x1 == W'(8) || x1 == W'(16) || x1 == W'(64))));
endmodule

bind flag_offset_loader ofl_chk #(.W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mst_rst_n(mst_rst_n), .ser_en_n(ser_en_n),
  .par_wr(par_wr), .mode(mode_q), .x1(x1_ofs), .y1(y1_ofs),
  .x2(x2_ofs), .y2(y2_ofs), .done(done)
);

// File: tb/flag_offset_loader_bench.sv
module flag_offset_loader_bench;
  localparam int W  = 8;
  localparam int NB = 4 * W;

  logic         clk = 1'b0;
  logic         rst_n, mst_rst_n, ser_mode_n, ser_en_n, ser_din, par_wr;
  logic [1:0]   fsel;
  logic [W-1:0] par_data;
  logic [W-1:0] x1_ofs, y1_ofs, x2_ofs, y2_ofs;
  logic         done;
  int           n_chk = 0;
  int           n_bad = 0;

  always #10 clk = ~clk;

  flag_offset_loader #(.OFS_W(W)) u_flag_offset_loader (
    .clk(clk), .rst_n(rst_n), .mst_rst_n(mst_rst_n), .ser_mode_n(ser_mode_n),
    .fsel(fsel), .ser_en_n(ser_en_n), .ser_din(ser_din), .par_data(par_data),
    .par_wr(par_wr), .x1_ofs(x1_ofs), .y1_ofs(y1_ofs), .x2_ofs(x2_ofs),
    .y2_ofs(y2_ofs), .done(done)
  );

  function automatic logic [W-1:0] exp_preset(input logic [1:0] s);
    case (s)
      2'd1:    return W'(8);
      2'd2:    return W'(16);
      2'd3:    return W'(64);
      default: return '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req, input logic [4*W-1:0] exp_x1y1x2y2, input logic exp_done);
    chk(req, {x1_ofs, y1_ofs, x2_ofs, y2_ofs}, exp_x1y1x2y2);
    chk(req, done, exp_done);
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic enter_reset(input logic m_n, input logic [1:0] s);
    @(negedge clk);
    mst_rst_n = 1'b0; ser_mode_n = m_n; fsel = s; ser_en_n = 1'b1; par_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 done low in master reset", done, 1'b0);
    mst_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic noise_cycle;
    ser_en_n = 1'($urandom); ser_din = 1'($urandom);
    par_wr = 1'($urandom); par_data = W'($urandom);
    @(negedge clk);
  endtask

  task automatic serial_load(input logic [NB-1:0] v, input int nbits);
    for (int i = NB - 1; i >= NB - nbits; i--) begin
      while ($urandom % 3 == 0) begin
        ser_en_n = 1'b1; ser_din = 1'($urandom);
        par_wr = 1'($urandom); par_data = W'($urandom);
        @(negedge clk);
      end
      if (i == 0) chk("R5 done low before last bit", done, 1'b0);
      ser_en_n = 1'b0; ser_din = v[i];
      par_wr = 1'($urandom); par_data = W'($urandom);
      @(negedge clk);
    end
    ser_en_n = 1'b1; par_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    logic [NB-1:0] v;
    logic [W-1:0]  pv [4];
    logic [NB-1:0] snap;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; mst_rst_n = 1'b0; ser_mode_n = 1'b1; fsel = 2'd0;
    ser_en_n = 1'b1; ser_din = 1'b0; par_wr = 1'b0; par_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Preset mode, each selection (R3), then pin changes and foreign inputs (R2, R9)
    for (int s = 1; s <= 3; s++) begin
      enter_reset(1'b1, 2'(s));
      chk_ofs("R3 preset", {4{exp_preset(2'(s))}}, 1'b1);
      fsel = 2'(s % 3 + 1); ser_mode_n = 1'b0;
      repeat (6) noise_cycle();
      ser_en_n = 1'b1; par_wr = 1'b0;
      chk_ofs("R2 R9 preset held after pin change", {4{exp_preset(2'(s))}}, 1'b1);
    end

    // Serial mode with random streams and colliding parallel strobes (R4, R5, R6, R9)
    for (int t = 0; t < 5; t++) begin
      enter_reset(1'b0, 2'($urandom));
      chk_ofs("R1 serial start zero", '0, 1'b0);
      ser_mode_n = 1'b1; fsel = 2'($urandom);
      v = (t == 0) ? {NB{1'b1}} : (t == 1) ? {1'b1, {(NB-2){1'b0}}, 1'b1} : NB'($urandom);
      serial_load(v, NB);
      chk_ofs("R4 R5 serial order", {v[3*W-1:2*W], v[4*W-1:3*W], v[W-1:0], v[2*W-1:W]}, 1'b1);
      for (int k = 0; k < 7; k++) begin
        ser_en_n = 1'b0; ser_din = 1'($urandom); par_wr = 1'b1; par_data = W'($urandom);
        @(negedge clk);
      end
      ser_en_n = 1'b1; par_wr = 1'b0;
      chk_ofs("R6 R11 extra serial bits ignored", {v[3*W-1:2*W], v[4*W-1:3*W], v[W-1:0], v[2*W-1:W]}, 1'b1);
    end

    // Parallel mode with colliding serial enables (R7, R8, R9)
    for (int t = 0; t < 5; t++) begin
      enter_reset(1'b1, 2'd0);
      chk_ofs("R1 parallel start zero", '0, 1'b0);
      ser_mode_n = 1'b0; fsel = 2'd3;
      for (int k = 0; k < 4; k++) pv[k] = (t == 0) ? W'(k + 1) : W'($urandom);
      for (int k = 0; k < 4; k++) begin
        while ($urandom % 3 == 0) begin
          par_wr = 1'b0; ser_en_n = 1'($urandom); ser_din = 1'($urandom);
          par_data = W'($urandom);
          @(negedge clk);
        end
        if (k == 3) chk("R7 done low before fourth write", done, 1'b0);
        par_wr = 1'b1; par_data = pv[k]; ser_en_n = 1'($urandom); ser_din = 1'($urandom);
        @(negedge clk);
      end
      par_wr = 1'b0; ser_en_n = 1'b1;
      chk_ofs("R7 parallel order", {pv[0], pv[1], pv[2], pv[3]}, 1'b1);
      for (int k = 0; k < 4; k++) begin
        par_wr = 1'b1; par_data = W'($urandom); ser_en_n = 1'b0;
        @(negedge clk);
      end
      par_wr = 1'b0; ser_en_n = 1'b1;
      chk_ofs("R8 R11 extra writes ignored", {pv[0], pv[1], pv[2], pv[3]}, 1'b1);
    end

    // Master reset during a serial load, then a parallel load (R10)
    enter_reset(1'b0, 2'd0);
    v = NB'($urandom);
    serial_load(v, 10);
    enter_reset(1'b1, 2'd0);
    chk_ofs("R10 reload clears", '0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      par_wr = 1'b1; par_data = W'(8'hA0 + k);
      @(negedge clk);
    end
    par_wr = 1'b0;
    chk_ofs("R10 new method loads", {W'(8'hA0), W'(8'hA1), W'(8'hA2), W'(8'hA3)}, 1'b1);
    enter_reset(1'b1, 2'd2);
    chk_ofs("R10 preset after parallel", {4{W'(16)}}, 1'b1);

    summary();
  end
endmodule